// File: doc/BRIEF.md
# Thermal Bus Client Command Responder

This block is the client-side command engine of a single-wire platform thermal management bus. An upstream framer hands it an already decoded request: the target address, a command byte, the first four write bytes and the number of response bytes the host will read. The responder checks whether the request is meant for it, builds a response byte array in a zero-cleared buffer and reports a frame-status flag. Bit timing, frame check sequence generation and all write-type or register-window commands belong to other blocks.

Four commands are answered: a presence check, a device-information read (info byte plus a revision that depends on the configured CPU family), a die temperature read returned as a signed offset from the junction limit, and a package-configuration mailbox read. The mailbox read returns a completion code followed by a 32-bit little-endian word; its two-level decode covers the identity words, the thermal margin in 10.6 fixed point, per-channel memory module temperatures, the temperature target and a fixed inventory word.

Control is a three-state machine. `ST_IDLE` raises `req_ready`; a request seen with `req_valid` moves it to `ST_BUILD` (transition *accept*), where the request is latched and the response is assembled. On the next edge it moves to `ST_DONE` (transition *publish*), registering the response and pulsing `rsp_done` for one cycle, then returns to `ST_IDLE` (transition *release*).

Top module: `thm_client_responder`

## Requirements
- R1: `req_ready` is high only in the idle state; a request is taken on a clock edge with `req_valid` and `req_ready` both high, `req_ready` is low in the two cycles after that edge, and `rsp_done` is high for exactly the second of them, together with the new response.
- R2: The client answers only when `req_addr` equals its configured address, which must lie in 0x30..0x37 (otherwise no address matches); a miss gives `rsp_fcs_err`=1 and all response bytes zero, a hit gives `rsp_fcs_err`=0.
- R3: Response byte i sits at `rsp_bytes[8i+7:8i]`; every byte at a position at or beyond `req_rlen`, and every byte the command does not write, reads as zero.
- R4: Command 0x00 (presence check) returns no payload.
- R5: Command 0xF7 returns byte 0 = device-info parameter, byte 1 = revision.
- R6: The revision is 0x31, 0x32, 0x36 or 0x40 for families 0x306F0, 0x406F0, 0x50650/0x50660 and 0x606A0/0x806F3; any other family gives 0x31.
- R7: Command 0x01 returns byte 0 = (hottest core temperature − junction limit) modulo 256.
- R8: Command 0xA1 takes the mailbox index from write byte 1 (`req_wbytes[15:8]`) and the parameter from write bytes 2 (low) and 3 (high); byte 0 is the completion code (0x40 for indices 0, 10, 14, 16, 19; 0x90 with zero data otherwise), bytes 1..4 the data word, least significant byte first.
- R9: Index 0 with parameter 0 returns the CPU family word, with parameter 4 the microcode word; any other parameter returns zero data.
- R10: Index 10 returns (junction limit − hottest core temperature), as a 32-bit two's complement value, shifted left by 6.
- R11: Index 14 returns, in data bytes 0..DIMMS_PER_CH−1, the module temperatures from entry min(parameter, 8)×DIMMS_PER_CH onward; entries beyond the table read as zero.
- R12: Index 16 returns data bytes {0x00, control offset (default −5 = 0xFB), junction limit (default 90 = 0x5A), 0x00}; index 19 returns 0xDEADBEEF.
- R13: Commands 0xB1, 0x61, 0xE1, 0xC1 and any unknown code on a hit return all-zero bytes with `rsp_fcs_err`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle, request can be taken |
| req_addr | input | 8 | Target client address |
| req_cmd | input | 8 | Command code |
| req_wbytes | input | 32 | Write bytes 0..3, byte i at [8i+7:8i] |
| req_rlen | input | RLEN_W | Requested response length in bytes |
| core_temp | input | NUM_CORES*8 | Per-core temperatures, unsigned degrees |
| dimm_temp | input | NUM_CHANNELS*DIMMS_PER_CH*8 | Per-module temperatures |
| rsp_done | output | 1 | One-cycle response strobe |
| rsp_fcs_err | output | 1 | Frame status: 1 when no client matched |
| rsp_bytes | output | BUF_BYTES*8 | Response bytes, byte i at [8i+7:8i] |

## Verification
The bench targets the channel clamp of the module-temperature read (parameters 9 and 0x0103 must both land on the empty channel 8; a design that skipped the clamp or ignored write byte 3 would return another channel's bytes), and the parameter word order. It drives a core hotter than the junction limit, where a design that treated the offset or margin as unsigned would give the wrong sign extension in 0xFFFFFEC0. Truncation by the read length is probed with short lengths on the info and mailbox reads, where a design that ignored the length would leak the revision or data bytes. A second instance with an unknown family and the top valid address checks the revision fallback, and a neighbouring valid address checks that a miss reports error with an empty payload.

// File: rtl/thm_resp_pkg.sv
package thm_resp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BUILD = 2'd1,
        ST_DONE  = 2'd2
    } thm_state_e;

    localparam logic [7:0] ADDR_LO = 8'h30;
    localparam logic [7:0] ADDR_HI = 8'h37;

    localparam logic [7:0] OP_PING  = 8'h00;
    localparam logic [7:0] OP_TEMP  = 8'h01;
    localparam logic [7:0] OP_PKGRD = 8'hA1;
    localparam logic [7:0] OP_INFO  = 8'hF7;

    localparam logic [7:0] CC_OK     = 8'h40;
    localparam logic [7:0] CC_BADREQ = 8'h90;

    localparam logic [7:0] MB_IDENT  = 8'd0;
    localparam logic [7:0] MB_MARGIN = 8'd10;
    localparam logic [7:0] MB_DIMM   = 8'd14;
    localparam logic [7:0] MB_TARGET = 8'd16;
    localparam logic [7:0] MB_SERIAL = 8'd19;

    localparam logic [15:0] PRM_CPUID = 16'd0;
    localparam logic [15:0] PRM_UCODE = 16'd4;

    localparam logic [31:0] SERIAL_WORD = 32'hDEADBEEF;

    function automatic logic [7:0] family_rev(input logic [31:0] fam);
        case (fam)
            32'h000306F0:               return 8'h31;
            32'h000406F0:               return 8'h32;
            32'h00050650, 32'h00050660: return 8'h36;
            32'h000606A0, 32'h000806F3: return 8'h40;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/thm_max_finder.sv
module thm_max_finder #(
    parameter int N = 4,
    parameter int W = 8
) (
    input  logic [N*W-1:0] vals,
    output logic [W-1:0]   max_val
);
    logic [N:0][W-1:0] run;

    assign run[0] = '0;

    for (genvar g = 0; g < N; g++) begin : g_stage
        assign run[g+1] = (vals[g*W +: W] > run[g]) ? vals[g*W +: W] : run[g];
    end

    assign max_val = run[N];
endmodule

// File: rtl/thm_pkgcfg_decoder.sv
module thm_pkgcfg_decoder
    import thm_resp_pkg::*;
#(
    parameter int          NUM_CHANNELS = 8,
    parameter int          DIMMS_PER_CH = 2,
    parameter int          TJ_MAX       = 90,
    parameter int          CTRL_OFFSET  = -5,
    parameter logic [31:0] CPU_WORD     = 32'h000606A0,
    parameter logic [31:0] UCODE_WORD   = 32'h8C0004A0,
    localparam int         NUM_DIMMS    = NUM_CHANNELS * DIMMS_PER_CH
) (
    input  logic [7:0]             index,
    input  logic [15:0]            param,
    input  logic [7:0]             hottest,
    input  logic [NUM_DIMMS*8-1:0] dimm_temp,
    output logic [7:0]             cc,
    output logic [31:0]            data
);
    int ch;

    always_comb begin
        cc   = CC_OK;
        data = '0;
        ch   = 0;
        case (index)
            MB_IDENT: begin
                if (param == PRM_CPUID)      data = CPU_WORD;
                else if (param == PRM_UCODE) data = UCODE_WORD;
            end
            MB_MARGIN: data = (32'(TJ_MAX) - {24'b0, hottest}) << 6;
            MB_DIMM: begin
                ch = (param > 16'(NUM_CHANNELS)) ? NUM_CHANNELS : int'(param);
                for (int j = 0; j < DIMMS_PER_CH; j++) begin
                    if (ch * DIMMS_PER_CH + j < NUM_DIMMS)
                        data[8*j +: 8] = dimm_temp[(ch * DIMMS_PER_CH + j) * 8 +: 8];
                end
            end
            MB_TARGET: data = {8'h00, 8'(TJ_MAX), 8'(CTRL_OFFSET), 8'h00};
            MB_SERIAL: data = SERIAL_WORD;
            default:   cc = CC_BADREQ;
        endcase
    end
endmodule

// File: rtl/thm_client_responder.sv
module thm_client_responder
    import thm_resp_pkg::*;
#(
    parameter logic [7:0]  CLIENT_ADDR  = 8'h30,
    parameter logic [31:0] CPU_FAMILY   = 32'h000606A0,
    parameter logic [31:0] UCODE_WORD   = 32'h8C0004A0,
    parameter logic [7:0]  DEV_INFO     = 8'h00,
    parameter int          NUM_CORES    = 4,
    parameter int          NUM_CHANNELS = 8,
    parameter int          DIMMS_PER_CH = 2,
    parameter int          BUF_BYTES    = 8,
    parameter int          TJ_MAX       = 90,
    parameter int          CTRL_OFFSET  = -5,
    localparam int         NUM_DIMMS    = NUM_CHANNELS * DIMMS_PER_CH,
    localparam int         RLEN_W       = $clog2(BUF_BYTES + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [7:0]             req_addr,
    input  logic [7:0]             req_cmd,
    input  logic [31:0]            req_wbytes,
    input  logic [RLEN_W-1:0]      req_rlen,
    input  logic [NUM_CORES*8-1:0] core_temp,
    input  logic [NUM_DIMMS*8-1:0] dimm_temp,
    output logic                   rsp_done,
    output logic                   rsp_fcs_err,
    output logic [BUF_BYTES*8-1:0] rsp_bytes
);
    localparam logic [7:0] REVISION   = family_rev(CPU_FAMILY);
    localparam bit         ADDR_LEGAL = (CLIENT_ADDR >= ADDR_LO) && (CLIENT_ADDR <= ADDR_HI);

    thm_state_e  state_q, state_d;
    logic [7:0]  addr_q, cmd_q;
    logic [31:0] wb_q;
    logic [RLEN_W-1:0] rlen_q;
    logic [7:0]  hottest, mb_cc;
    logic [31:0] mb_data;
    logic [BUF_BYTES-1:0][7:0] frame_c;
    logic        hit, accept;

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign hit       = ADDR_LEGAL && (addr_q == CLIENT_ADDR);

    thm_max_finder #(.N(NUM_CORES), .W(8)) u_core_max (
        .vals    (core_temp),
        .max_val (hottest)
    );

    thm_pkgcfg_decoder #(
        .NUM_CHANNELS (NUM_CHANNELS),
        .DIMMS_PER_CH (DIMMS_PER_CH),
        .TJ_MAX       (TJ_MAX),
        .CTRL_OFFSET  (CTRL_OFFSET),
        .CPU_WORD     (CPU_FAMILY),
        .UCODE_WORD   (UCODE_WORD)
    ) u_mailbox (
        .index     (wb_q[15:8]),
        .param     (wb_q[31:16]),
        .hottest   (hottest),
        .dimm_temp (dimm_temp),
        .cc        (mb_cc),
        .data      (mb_data)
    );

    // next-state: accept, publish, release
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept) state_d = ST_BUILD;
            ST_BUILD: state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            cmd_q  <= '0;
            wb_q   <= '0;
            rlen_q <= '0;
        end else if (accept) begin
            addr_q <= req_addr;
            cmd_q  <= req_cmd;
            wb_q   <= req_wbytes;
            rlen_q <= req_rlen;
        end
    end

    // response assembly in a zero-cleared buffer, truncated to the read length
    always_comb begin
        frame_c = '0;
        case (cmd_q)
            OP_INFO: begin
                frame_c[0] = DEV_INFO;
                frame_c[1] = REVISION;
            end
            OP_TEMP:  frame_c[0] = hottest - 8'(TJ_MAX);
            OP_PKGRD: begin
                frame_c[0] = mb_cc;
                frame_c[1] = mb_data[7:0];
                frame_c[2] = mb_data[15:8];
                frame_c[3] = mb_data[23:16];
                frame_c[4] = mb_data[31:24];
            end
            default: ;
        endcase
        for (int i = 0; i < BUF_BYTES; i++) begin
            if (i >= int'(rlen_q)) frame_c[i] = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_done    <= 1'b0;
            rsp_fcs_err <= 1'b0;
            rsp_bytes   <= '0;
        end else begin
            rsp_done <= 1'b0;
            if (state_q == ST_BUILD) begin
                rsp_done    <= 1'b1;
                rsp_fcs_err <= !hit;
                rsp_bytes   <= hit ? frame_c : '0;
            end
        end
    end

    // R1
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);
    // R1
    busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
    // R1
    done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> ##1 rsp_done);
    // R2
    miss_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && rsp_fcs_err) |-> (rsp_bytes == '0));
    // R3
    zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && rlen_q == '0) |-> (rsp_bytes == '0));
    // R8
    cc_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && !rsp_fcs_err && cmd_q == OP_PKGRD && rlen_q != '0)
        |-> (rsp_bytes[7:0] == CC_OK || rsp_bytes[7:0] == CC_BADREQ));
endmodule

// File: tb/thm_client_responder_bench.sv
module thm_client_responder_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NCORE = 4;
    localparam int NDIMM = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [7:0]  req_addr = '0;
    logic [7:0]  req_cmd = '0;
    logic [31:0] req_wbytes = '0;
    logic [3:0]  req_rlen = '0;
    logic [NCORE*8-1:0] core_temp;
    logic [NDIMM*8-1:0] dimm_temp;
    logic        rsp_done, rsp_fcs_err;
    logic [63:0] rsp_bytes;

    logic        a_valid = 1'b0;
    logic        a_ready;
    logic [7:0]  a_addr = '0;
    logic [7:0]  a_cmd = '0;
    logic        a_done, a_err;
    logic [63:0] a_bytes;

    int n_checks = 0;
    int n_fails  = 0;

    logic        exp_err_q[$];
    logic [63:0] exp_data_q[$];
    string       exp_tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    thm_client_responder u_thm_client_responder (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_cmd(req_cmd), .req_wbytes(req_wbytes),
        .req_rlen(req_rlen), .core_temp(core_temp), .dimm_temp(dimm_temp),
        .rsp_done(rsp_done), .rsp_fcs_err(rsp_fcs_err), .rsp_bytes(rsp_bytes)
    );

    thm_client_responder #(.CLIENT_ADDR(8'h37), .CPU_FAMILY(32'h00012345)) u_alt_thm_client_responder (
        .clk(clk), .rst_n(rst_n), .req_valid(a_valid), .req_ready(a_ready),
        .req_addr(a_addr), .req_cmd(a_cmd), .req_wbytes(32'h0),
        .req_rlen(4'd8), .core_temp(core_temp), .dimm_temp(dimm_temp),
        .rsp_done(a_done), .rsp_fcs_err(a_err), .rsp_bytes(a_bytes)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] trunc(input logic [63:0] v, input int n);
        logic [63:0] r = v;
        for (int i = 0; i < 8; i++) if (i >= n) r[8*i +: 8] = '0;
        return r;
    endfunction

    function automatic logic [63:0] mbox(input logic [7:0] cc, input logic [31:0] d);
        return {24'h0, d, cc};
    endfunction

    function automatic logic [31:0] wb(input logic [7:0] idx, input logic [15:0] prm);
        return {prm, idx, 8'h00};
    endfunction

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && rsp_done) begin
            if (exp_tag_q.size() == 0) begin
                chk(1'b0, "R1 unexpected done", {63'h0, rsp_done}, 64'h0);
            end else begin
                automatic logic        e_err = exp_err_q.pop_front();
                automatic logic [63:0] e_dat = exp_data_q.pop_front();
                automatic string       e_tag = exp_tag_q.pop_front();
                chk(rsp_fcs_err == e_err, {e_tag, " status"}, {63'h0, rsp_fcs_err}, {63'h0, e_err});
                chk(rsp_bytes == e_dat, {e_tag, " bytes"}, rsp_bytes, e_dat);
            end
        end
    end

    task automatic send(input logic [7:0] addr, input logic [7:0] cmd, input logic [31:0] w,
                        input int rlen, input logic e_err, input logic [63:0] e_full, input string tag);
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready idle", {63'h0, req_ready}, 64'h1);
        req_valid  = 1'b1;
        req_addr   = addr;
        req_cmd    = cmd;
        req_wbytes = w;
        req_rlen   = 4'(rlen);
        exp_err_q.push_back(e_err);
        exp_data_q.push_back(e_err ? 64'h0 : trunc(e_full, rlen));
        exp_tag_q.push_back(tag);
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0 && rsp_done == 1'b0, "R1 busy after accept",
            {62'h0, req_ready, rsp_done}, 64'h0);
        @(negedge clk);
        chk(rsp_done == 1'b1 && req_ready == 1'b0, "R1 done strobe",
            {62'h0, req_ready, rsp_done}, 64'h1);
        @(negedge clk);
        chk(rsp_done == 1'b0 && req_ready == 1'b1, "R1 release",
            {62'h0, req_ready, rsp_done}, 64'h2);
    endtask

    task automatic set_cores(input logic [7:0] c0, input logic [7:0] c1, input logic [7:0] c2, input logic [7:0] c3);
        core_temp = {c3, c2, c1, c0};
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < NDIMM; i++) dimm_temp[8*i +: 8] = 8'h20 + 8'(i);
        set_cores(8'd50, 8'd70, 8'd65, 8'd30);
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !rsp_done && !rsp_fcs_err && rsp_bytes == '0, "R1 reset state",
            {rsp_bytes[61:0], req_ready, rsp_done}, 64'h2);

        // R4 / R2
        send(8'h30, 8'h00, 32'h0, 8, 1'b0, 64'h0, "R4 ping hit");
        send(8'h31, 8'h00, 32'h0, 8, 1'b1, 64'h0, "R2 miss neighbour");
        send(8'h40, 8'hF7, 32'h0, 8, 1'b1, 64'h0, "R2 miss out of range");
        // R5 / R6
        send(8'h30, 8'hF7, 32'h0, 8, 1'b0, 64'h4000, "R5 R6 info");
        // R3 truncation
        send(8'h30, 8'hF7, 32'h0, 1, 1'b0, 64'h4000, "R3 info len1");
        send(8'h30, 8'hF7, 32'h0, 0, 1'b0, 64'h4000, "R3 info len0");
        // R7
        send(8'h30, 8'h01, 32'h0, 8, 1'b0, 64'hEC, "R7 temp below");
        // R9
        send(8'h30, 8'hA1, wb(8'd0, 16'd0), 8, 1'b0, mbox(8'h40, 32'h000606A0), "R9 cpu word");
        send(8'h30, 8'hA1, wb(8'd0, 16'd4), 8, 1'b0, mbox(8'h40, 32'h8C0004A0), "R9 microcode");
        send(8'h30, 8'hA1, wb(8'd0, 16'd2), 8, 1'b0, mbox(8'h40, 32'h0), "R9 other param");
        // R10
        send(8'h30, 8'hA1, wb(8'd10, 16'd0), 8, 1'b0, mbox(8'h40, 32'h00000500), "R10 margin 20");
        // R11
        send(8'h30, 8'hA1, wb(8'd14, 16'd3), 8, 1'b0, mbox(8'h40, 32'h00002726), "R11 channel 3");
        send(8'h30, 8'hA1, wb(8'd14, 16'd7), 8, 1'b0, mbox(8'h40, 32'h00002F2E), "R11 channel 7");
        send(8'h30, 8'hA1, wb(8'd14, 16'd9), 8, 1'b0, mbox(8'h40, 32'h0), "R11 clamp 9");
        send(8'h30, 8'hA1, wb(8'd14, 16'h0103), 8, 1'b0, mbox(8'h40, 32'h0), "R11 clamp high byte");
        // R12
        send(8'h30, 8'hA1, wb(8'd16, 16'd0), 8, 1'b0, mbox(8'h40, 32'h005AFB00), "R12 target");
        send(8'h30, 8'hA1, wb(8'd19, 16'd0), 8, 1'b0, mbox(8'h40, 32'hDEADBEEF), "R12 inventory");
        // R8
        send(8'h30, 8'hA1, wb(8'd5, 16'd0), 8, 1'b0, mbox(8'h90, 32'h0), "R8 bad index");
        send(8'h30, 8'hA1, wb(8'd19, 16'd0), 3, 1'b0, mbox(8'h40, 32'hDEADBEEF), "R8 R3 len3");
        // R13
        send(8'h30, 8'hB1, 32'hFFFFFFFF, 8, 1'b0, 64'h0, "R13 0xB1");
        send(8'h30, 8'h61, 32'hFFFFFFFF, 8, 1'b0, 64'h0, "R13 0x61");
        send(8'h30, 8'hE1, 32'hFFFFFFFF, 8, 1'b0, 64'h0, "R13 0xE1");
        send(8'h30, 8'hC1, 32'hFFFFFFFF, 8, 1'b0, 64'h0, "R13 0xC1");
        send(8'h30, 8'h55, 32'hFFFFFFFF, 8, 1'b0, 64'h0, "R13 unknown");
        // core above the junction limit
        set_cores(8'd50, 8'd70, 8'd95, 8'd30);
        send(8'h30, 8'h01, 32'h0, 8, 1'b0, 64'h05, "R7 temp above");
        send(8'h30, 8'hA1, wb(8'd10, 16'd0), 8, 1'b0, mbox(8'h40, 32'hFFFFFEC0), "R10 margin negative");

        // R6 fallback revision on second client at 0x37
        @(negedge clk);
        a_valid = 1'b1; a_addr = 8'h37; a_cmd = 8'hF7;
        @(negedge clk);
        a_valid = 1'b0;
        @(negedge clk);
        chk(a_done && !a_err && a_bytes == 64'h3100, "R6 fallback revision", a_bytes, 64'h3100);

        repeat (3) @(negedge clk);
        chk(exp_tag_q.size() == 0, "R1 all responses seen", 64'(exp_tag_q.size()), 64'h0);
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule